// File: doc/BRIEF.md
# Framed Serial Even-Parity Checker

This block receives a bit-serial frame one bit at a time and judges whether the frame has even parity. A start pulse opens a frame. Each bit is taken on a cycle where the bit strobe is high. The first seven bits taken are data and the eighth is the parity bit. When the eighth bit has been taken, the block gives a one-cycle completion pulse. An error flag is set if the eight bits together hold an odd number of ones. The seven data bits are also presented on a parallel output.

A start pulse always reopens the frame at position 0, even in the middle of a frame. It also clears the running parity, the captured data and the error flag. Once a frame has completed, the block takes no more bits until the next start pulse. Gaps between strobes are allowed at any point. Reset is asserted asynchronously and released through a two-stage synchroniser.

Top module: `frame_parity_chk`

## Requirements
- R1: After reset, `frame_done_o` and `parity_err_o` are 0 and `data_o` is all zeros. No frame is open, so strobed bits are not taken before the first start pulse.
- R2: A cycle with `sync_i` high opens a frame at position 0 whatever the current position. On the next edge it sets `data_o` to 0 and `parity_err_o` to 0.
- R3: A bit is taken on a clock edge where `bit_vld_i` is high, `sync_i` is low and a frame is open. The first seven bits taken are data and the eighth is the parity bit.
- R4: Each data bit shifts into `data_o` at bit 0 and the older bits move up one place. The first data bit of a frame therefore ends up in bit 6 and the last in bit 0.
- R5: `frame_done_o` is high for exactly one cycle: the cycle after the edge that takes the parity bit.
- R6: In the cycle where `frame_done_o` is high, `parity_err_o` equals the XOR of the seven data bits and the parity bit (1 means odd, which is a bad frame). It keeps that value until the next start pulse or the next frame completion.
- R7: After a frame completes, strobed bits are ignored until the next start pulse. No completion pulse follows, and `data_o` and `parity_err_o` keep their values.
- R8: If `sync_i` and `bit_vld_i` are high in the same cycle, the frame restarts and that cycle's bit is discarded.
- R9: Cycles with `bit_vld_i` low do not move the frame position, so any spacing between bits gives the same result.
- R10: A start pulse partway through a frame discards the bits already taken. The next completion reflects only the bits taken after that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_i | input | 1 | Frame start pulse |
| bit_vld_i | input | 1 | Strobe marking `bit_i` as valid this cycle |
| bit_i | input | 1 | Serial data bit |
| frame_done_o | output | 1 | One-cycle pulse after the parity bit is taken |
| parity_err_o | output | 1 | Parity error of the last completed frame |
| data_o | output | DATA_BITS (7) | Captured data bits, first received bit in the MSB |

## Verification
The bench sends frames with an even and an odd count of ones. A checker that inverted the parity rule or skipped the parity bit would flag the wrong frames. A start pulse that arrives together with a strobe must discard the bit; a design that took it would complete one bit early with shifted data. Further frames test a restart partway through a frame, strobes after completion and irregular gaps between bits. A design that failed to clear its position or parity, or that kept counting past the eighth bit, would give a stray completion pulse or corrupt the held data and flag.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [0:0] {
    FPC_WAIT_SYNC = 1'b0,
    FPC_IN_FRAME  = 1'b1
  } fpc_phase_e;
endpackage

// File: rtl/fpc_rst_sync.sv
module fpc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/fpc_pos_ctrl.sv
module fpc_pos_ctrl #(
  parameter int DATA_BITS = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic bit_vld_i,
  output logic take_data_o,
  output logic take_par_o
);
  import fpc_pkg::*;

  localparam int POS_W = $clog2(DATA_BITS + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(DATA_BITS);

  fpc_phase_e       phase_q, phase_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             accept;

  assign accept      = bit_vld_i && !sync_i && (phase_q == FPC_IN_FRAME);
  assign take_data_o = accept && (pos_q < LAST_POS);
  assign take_par_o  = accept && (pos_q == LAST_POS);

  always_comb begin
    phase_d = phase_q;
    pos_d   = pos_q;
    if (sync_i) begin
      phase_d = FPC_IN_FRAME;
      pos_d   = '0;
    end else if (take_data_o) begin
      pos_d   = pos_q + 1'b1;
    end else if (take_par_o) begin
      phase_d = FPC_WAIT_SYNC;
      pos_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= FPC_WAIT_SYNC;
      pos_q   <= '0;
    end else begin
      phase_q <= phase_d;
      pos_q   <= pos_d;
    end
  end
endmodule

// File: rtl/fpc_shreg.sv
module fpc_shreg #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] data_o
);
  logic [WIDTH-1:0] sh_q, sh_d;
  logic             sh_en;

  assign sh_en = clr_i || shift_i;

  always_comb begin
    if (clr_i) sh_d = '0;
    else       sh_d = {sh_q[WIDTH-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  assign data_o = sh_q;
endmodule

// File: rtl/fpc_par_eval.sv
module fpc_par_eval (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic take_data_i,
  input  logic take_par_i,
  input  logic bit_i,
  output logic done_o,
  output logic err_o
);
  logic par_q, par_d, par_en;
  logic err_q, err_d, err_en;
  logic done_q;

  assign par_en = clr_i || take_data_i;
  assign par_d  = clr_i ? 1'b0 : (par_q ^ bit_i);

  assign err_en = clr_i || take_par_i;
  assign err_d  = clr_i ? 1'b0 : (par_q ^ bit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      par_q <= 1'b0;
    else if (par_en) par_q <= par_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= take_par_i;
  end

  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/frame_parity_chk.sv
module frame_parity_chk #(
  parameter int DATA_BITS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_i,
  input  logic                 bit_vld_i,
  input  logic                 bit_i,
  output logic                 frame_done_o,
  output logic                 parity_err_o,
  output logic [DATA_BITS-1:0] data_o
);
  logic rst_int_n;
  logic take_data;
  logic take_par;

  fpc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  fpc_pos_ctrl #(.DATA_BITS(DATA_BITS)) u_pos (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sync_i      (sync_i),
    .bit_vld_i   (bit_vld_i),
    .take_data_o (take_data),
    .take_par_o  (take_par)
  );

  fpc_shreg #(.WIDTH(DATA_BITS)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr_i   (sync_i),
    .shift_i (take_data),
    .bit_i   (bit_i),
    .data_o  (data_o)
  );

  fpc_par_eval u_par (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .clr_i       (sync_i),
    .take_data_i (take_data),
    .take_par_i  (take_par),
    .bit_i       (bit_i),
    .done_o      (frame_done_o),
    .err_o       (parity_err_o)
  );
endmodule

// File: rtl/fpc_chk.sv
module fpc_chk #(
  parameter int DATA_BITS = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sync_i,
  input logic                 frame_done_o,
  input logic                 parity_err_o,
  input logic [DATA_BITS-1:0] data_o
);
  // R5
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o);

  // R8
  sync_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> !frame_done_o);

  // R2
  sync_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> (!parity_err_o && (data_o == '0)));

  // R7
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done_o && !sync_i) |=> ($stable(data_o) && !frame_done_o));

  // R6
  err_change_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(parity_err_o) |-> (frame_done_o || $past(sync_i)));
endmodule

bind frame_parity_chk fpc_chk #(.DATA_BITS(DATA_BITS)) u_fpc_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sync_i       (sync_i),
  .frame_done_o (frame_done_o),
  .parity_err_o (parity_err_o),
  .data_o       (data_o)
);

// File: tb/tb_frame_parity_chk.sv
module tb_frame_parity_chk;
  logic       clk;
  logic       rst_n;
  logic       sync_i;
  logic       bit_vld_i;
  logic       bit_i;
  logic       frame_done_o;
  logic       parity_err_o;
  logic [6:0] data_o;

  int checks;
  int failures;
  int done_cnt;

  frame_parity_chk #(.DATA_BITS(7)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_i       (sync_i),
    .bit_vld_i    (bit_vld_i),
    .bit_i        (bit_i),
    .frame_done_o (frame_done_o),
    .parity_err_o (parity_err_o),
    .data_o       (data_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) if (frame_done_o) done_cnt <= done_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic v, input logic d);
    @(negedge clk);
    sync_i = s; bit_vld_i = v; bit_i = d;
  endtask

  task automatic idle_cyc();
    cyc(1'b0, 1'b0, 1'b0);
  endtask

  // Sends data bits (first sent = d[6]) then parity; optional idle gaps.
  task automatic send_body(input logic [6:0] d, input logic p, input int gap);
    for (int i = 6; i >= 0; i--) begin
      cyc(1'b0, 1'b1, d[i]);
      for (int g = 0; g < gap; g++) idle_cyc();
    end
    cyc(1'b0, 1'b1, p);
  endtask

  task automatic check_frame(input string req, input logic [6:0] d, input logic p);
    int c0;
    c0 = done_cnt;
    idle_cyc();
    chk({req, " done pulse"}, frame_done_o, 1'b1);
    chk({req, " parity err"}, parity_err_o, ^{d, p});
    chk({req, " data"}, data_o, d);
    idle_cyc();
    chk({req, " done one cycle"}, frame_done_o, 1'b0);
    chk({req, " err held"}, parity_err_o, ^{d, p});
    chk({req, " done count"}, done_cnt - c0, 1);
  endtask

  task automatic t_reset();
    chk("R1 done at reset", frame_done_o, 1'b0);
    chk("R1 err at reset", parity_err_o, 1'b0);
    chk("R1 data at reset", data_o, 7'h00);
    for (int i = 0; i < 9; i++) cyc(1'b0, 1'b1, 1'b1);
    idle_cyc(); idle_cyc();
    chk("R1 no frame before sync", done_cnt, 0);
    chk("R1 data untouched before sync", data_o, 7'h00);
  endtask

  task automatic t_good_frame();
    cyc(1'b1, 1'b0, 1'b0);
    send_body(7'b1011001, 1'b0, 0);
    check_frame("R3 R4 R5 R6 even", 7'b1011001, 1'b0);
  endtask

  task automatic t_bad_frame();
    cyc(1'b1, 1'b0, 1'b0);
    send_body(7'b1110000, 1'b0, 0);
    check_frame("R6 odd", 7'b1110000, 1'b0);
    repeat (3) idle_cyc();
    chk("R6 err holds", parity_err_o, 1'b1);
    cyc(1'b1, 1'b0, 1'b0);
    idle_cyc();
    chk("R2 sync clears err", parity_err_o, 1'b0);
    chk("R2 sync clears data", data_o, 7'h00);
  endtask

  task automatic t_gaps();
    cyc(1'b1, 1'b0, 1'b0);
    send_body(7'b0100111, 1'b1, 2);
    check_frame("R9 gaps", 7'b0100111, 1'b1);
  endtask

  task automatic t_ignore_after();
    int c0;
    cyc(1'b1, 1'b0, 1'b0);
    send_body(7'b0000001, 1'b0, 0);
    check_frame("R7 base", 7'b0000001, 1'b0);
    c0 = done_cnt;
    for (int i = 0; i < 9; i++) cyc(1'b0, 1'b1, 1'b0);
    idle_cyc(); idle_cyc();
    chk("R7 no extra done", done_cnt - c0, 0);
    chk("R7 data kept", data_o, 7'b0000001);
    chk("R7 err kept", parity_err_o, 1'b1);
  endtask

  task automatic t_restart();
    cyc(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b1);
    cyc(1'b1, 1'b0, 1'b0);
    send_body(7'b0011000, 1'b0, 0);
    check_frame("R10 R2 restart", 7'b0011000, 1'b0);
  endtask

  task automatic t_sync_with_bit();
    int c0;
    cyc(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0);
    c0 = done_cnt;
    cyc(1'b1, 1'b1, 1'b1);
    for (int i = 6; i >= 0; i--) cyc(1'b0, 1'b1, 1'(i % 2));
    idle_cyc();
    chk("R8 no early done", done_cnt - c0, 0);
    chk("R8 data before parity", data_o, 7'b0101010);
    cyc(1'b0, 1'b1, 1'b0);
    check_frame("R8 sync wins", 7'b0101010, 1'b0);
  endtask

  initial begin
    checks = 0; failures = 0; done_cnt = 0;
    rst_n = 1'b0; sync_i = 1'b0; bit_vld_i = 1'b0; bit_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_good_frame();
    t_bad_frame();
    t_gaps();
    t_ignore_after();
    t_restart();
    t_sync_with_bit();
    repeat (2) idle_cyc();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule